// File: doc/BRIEF.md
# Peripheral Macrocell Slice

This block is a small slice of programmable logic that sits between a product-term array and two neighbours: a counter/timer and an interrupt controller. It holds six identical macrocells. Each one ORs its pair of product terms and then passes the result through a configurable storage and polarity stage. Per-cell configuration bits choose whether the cell presents the clocked copy of the OR or the live OR. A second bit chooses whether the result is inverted.

The first four macrocells serve the timer. Each of these outputs competes with an external timer pin in its own two-way selector, and the selector produces one of four load/store/enable strobes. The last two macrocells serve the interrupt controller. They join two raw product terms, which pass straight through with no storage and no inversion, to form four user interrupt requests. The product-term array, the timer and the interrupt controller lie outside this block.

Top module: `ppl_slice`

## Requirements
- R1: With `cfg_reg[i]`=0, macrocell i outputs (OR of its two product terms `pt_in[2i+1:2i]`) XOR `cfg_inv[i]` in the same cycle, with no clock edge needed.
- R2: With `cfg_reg[i]`=1, macrocell i outputs the OR of its product terms sampled at the previous rising clock edge, XOR `cfg_inv[i]`.
- R3: A rising edge with `rst`=1 clears every macrocell register to 0, so each registered cell then outputs exactly `cfg_inv[i]`.
- R4: For timer strobe j (0..3), `tmr_sel[j]`=1 drives `tmr_strobe[j]` from macrocell j and `tmr_sel[j]`=0 drives it from `tmr_pin[j]`.
- R5: `irq_req[1:0]` equal `pt_raw[1:0]` bit for bit in the same cycle, unaffected by any configuration bit.
- R6: `irq_req[2]` is macrocell 4 and `irq_req[3]` is macrocell 5, each following R1/R2 for its own configuration.
- R7: A macrocell register samples its OR on every edge even while the cell is in combinational mode, so switching `cfg_reg[i]` from 0 to 1 at once shows the OR from the last edge.
- R8: Inversion is applied after the register. Toggling `cfg_inv[i]` flips a registered output within the same cycle, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Macrocell register clock |
| rst | input | 1 | Synchronous active-high clear of the macrocell registers |
| pt_in | input | 12 | Product terms, two per macrocell; cell i uses bits 2i+1:2i |
| pt_raw | input | 2 | Raw product terms forwarded as interrupt requests 0 and 1 |
| tmr_pin | input | 4 | External timer control pins |
| cfg_reg | input | 6 | Per cell: 1 = registered output, 0 = combinational output |
| cfg_inv | input | 6 | Per cell: 1 = invert output |
| tmr_sel | input | 4 | Per strobe: 1 = macrocell, 0 = pin |
| tmr_strobe | output | 4 | Load/store/enable strobes to the counter/timer |
| irq_req | output | 4 | User interrupt requests to the interrupt controller |

## Verification
On every cycle the assertions check the combinational and the registered cell laws, the reset clear and the per-strobe selector. They also check that the raw terms and cells 4 and 5 reach the interrupt vector. Some effects show only across a sequence, and only the bench scenarios exercise them. One is the hidden register history revealed when a cell switches from combinational to registered mode (R7). Another is an inversion flip landing without a clock edge (R8). A third is random interleaving of configuration changes with product-term activity.

// File: rtl/ppl_pkg.sv
package ppl_pkg;

    localparam int DEF_TMR_N     = 4;
    localparam int DEF_IRQ_CELLS = 2;
    localparam int DEF_IRQ_RAW   = 2;
    localparam int DEF_PT_PER    = 2;

    typedef struct packed {
        logic use_reg;
        logic invert;
    } cell_cfg_t;

    typedef enum logic {
        SRC_PIN  = 1'b0,
        SRC_CELL = 1'b1
    } strobe_src_e;

    function automatic logic apply_polarity(input logic v, input logic inv);
        return v ^ inv;
    endfunction

    function automatic logic pick_source(input strobe_src_e s, input logic cell_v,
                                         input logic pin_v);
        return (s == SRC_CELL) ? cell_v : pin_v;
    endfunction

endpackage

// File: rtl/ppl_cell.sv
module ppl_cell
    import ppl_pkg::*;
#(
    parameter int PT_W = DEF_PT_PER
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PT_W-1:0] pt,
    input  cell_cfg_t       cfg,
    output logic            cell_out
);

    logic sum;
    logic sum_q;
    logic pre;

    assign sum = |pt;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= 1'b0;
        end else begin
            sum_q <= sum;
        end
    end

    assign pre      = cfg.use_reg ? sum_q : sum;
    assign cell_out = apply_polarity(pre, cfg.invert);

endmodule

// File: rtl/ppl_strobe_mux.sv
module ppl_strobe_mux
    import ppl_pkg::*;
#(
    parameter int N = DEF_TMR_N
) (
    input  logic [N-1:0] sel,
    input  logic [N-1:0] cell_v,
    input  logic [N-1:0] pin_v,
    output logic [N-1:0] strobe
);

    for (genvar j = 0; j < N; j++) begin : g_lane
        strobe_src_e src;
        assign src       = strobe_src_e'(sel[j]);
        assign strobe[j] = pick_source(src, cell_v[j], pin_v[j]);
    end

endmodule

// File: rtl/ppl_irq_merge.sv
module ppl_irq_merge
    import ppl_pkg::*;
#(
    parameter int RAW_N  = DEF_IRQ_RAW,
    parameter int CELL_N = DEF_IRQ_CELLS
) (
    input  logic [RAW_N-1:0]        raw,
    input  logic [CELL_N-1:0]       cell_v,
    output logic [RAW_N+CELL_N-1:0] irq
);

    for (genvar k = 0; k < RAW_N; k++) begin : g_raw
        assign irq[k] = raw[k];
    end

    for (genvar k = 0; k < CELL_N; k++) begin : g_cell
        assign irq[RAW_N+k] = cell_v[k];
    end

endmodule

// File: rtl/ppl_slice.sv
module ppl_slice
    import ppl_pkg::*;
#(
    parameter int TMR_N     = DEF_TMR_N,
    parameter int IRQ_CELLS = DEF_IRQ_CELLS,
    parameter int IRQ_RAW   = DEF_IRQ_RAW,
    parameter int PT_PER    = DEF_PT_PER,
    localparam int CELLS    = TMR_N + IRQ_CELLS,
    localparam int PT_W     = CELLS * PT_PER,
    localparam int IRQ_N    = IRQ_RAW + IRQ_CELLS
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [PT_W-1:0]  pt_in,
    input  logic [IRQ_RAW-1:0] pt_raw,
    input  logic [TMR_N-1:0] tmr_pin,
    input  logic [CELLS-1:0] cfg_reg,
    input  logic [CELLS-1:0] cfg_inv,
    input  logic [TMR_N-1:0] tmr_sel,
    output logic [TMR_N-1:0] tmr_strobe,
    output logic [IRQ_N-1:0] irq_req
);

    logic [CELLS-1:0] cell_out;

    for (genvar i = 0; i < CELLS; i++) begin : g_cell
        cell_cfg_t cfg_i;
        assign cfg_i.use_reg = cfg_reg[i];
        assign cfg_i.invert  = cfg_inv[i];

        ppl_cell #(.PT_W(PT_PER)) u_cell (
            .clk      (clk),
            .rst      (rst),
            .pt       (pt_in[i*PT_PER +: PT_PER]),
            .cfg      (cfg_i),
            .cell_out (cell_out[i])
        );
    end

    ppl_strobe_mux #(.N(TMR_N)) u_mux (
        .sel    (tmr_sel),
        .cell_v (cell_out[TMR_N-1:0]),
        .pin_v  (tmr_pin),
        .strobe (tmr_strobe)
    );

    ppl_irq_merge #(.RAW_N(IRQ_RAW), .CELL_N(IRQ_CELLS)) u_irq (
        .raw    (pt_raw),
        .cell_v (cell_out[CELLS-1:TMR_N]),
        .irq    (irq_req)
    );

endmodule

// File: rtl/ppl_slice_chk.sv
module ppl_slice_chk #(
    parameter int TMR_N     = 4,
    parameter int IRQ_CELLS = 2,
    parameter int IRQ_RAW   = 2,
    parameter int PT_PER    = 2,
    localparam int CELLS    = TMR_N + IRQ_CELLS,
    localparam int PT_W     = CELLS * PT_PER,
    localparam int IRQ_N    = IRQ_RAW + IRQ_CELLS
) (
    input logic               clk,
    input logic               rst,
    input logic [PT_W-1:0]    pt_in,
    input logic [IRQ_RAW-1:0] pt_raw,
    input logic [TMR_N-1:0]   tmr_pin,
    input logic [CELLS-1:0]   cfg_reg,
    input logic [CELLS-1:0]   cfg_inv,
    input logic [TMR_N-1:0]   tmr_sel,
    input logic [TMR_N-1:0]   tmr_strobe,
    input logic [IRQ_N-1:0]   irq_req,
    input logic [CELLS-1:0]   cell_out
);

    logic armed;
    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    for (genvar i = 0; i < CELLS; i++) begin : g_c
        // R1
        a_r1_comb_cell: assert property (@(posedge clk) disable iff (rst)
            !cfg_reg[i] |-> cell_out[i] == ((|pt_in[i*PT_PER +: PT_PER]) ^ cfg_inv[i]));
        // R2
        a_r2_reg_cell: assert property (@(posedge clk) disable iff (rst)
            (armed && cfg_reg[i] && !$past(rst))
            |-> cell_out[i] == ((|$past(pt_in[i*PT_PER +: PT_PER])) ^ cfg_inv[i]));
        // R3
        a_r3_reset_clear: assert property (@(posedge clk) disable iff (rst)
            ($past(rst) && cfg_reg[i]) |-> cell_out[i] == cfg_inv[i]);
    end

    for (genvar j = 0; j < TMR_N; j++) begin : g_t
        // R4
        a_r4_strobe_sel: assert property (@(posedge clk) disable iff (rst)
            tmr_strobe[j] == (tmr_sel[j] ? cell_out[j] : tmr_pin[j]));
    end

    // R5
    a_r5_raw_pass: assert property (@(posedge clk) disable iff (rst)
        irq_req[IRQ_RAW-1:0] == pt_raw);

    // R6
    a_r6_irq_cells: assert property (@(posedge clk) disable iff (rst)
        irq_req[IRQ_N-1:IRQ_RAW] == cell_out[CELLS-1:TMR_N]);

endmodule

bind ppl_slice ppl_slice_chk #(
    .TMR_N(TMR_N), .IRQ_CELLS(IRQ_CELLS), .IRQ_RAW(IRQ_RAW), .PT_PER(PT_PER)
) u_chk (
    .clk(clk), .rst(rst), .pt_in(pt_in), .pt_raw(pt_raw), .tmr_pin(tmr_pin),
    .cfg_reg(cfg_reg), .cfg_inv(cfg_inv), .tmr_sel(tmr_sel),
    .tmr_strobe(tmr_strobe), .irq_req(irq_req), .cell_out(cell_out)
);

// File: tb/test_ppl_slice.sv
module test_ppl_slice;

    logic        clk = 1'b0;
    logic        rst;
    logic [11:0] pt_in;
    logic [1:0]  pt_raw;
    logic [3:0]  tmr_pin;
    logic [5:0]  cfg_reg;
    logic [5:0]  cfg_inv;
    logic [3:0]  tmr_sel;
    logic [3:0]  tmr_strobe;
    logic [3:0]  irq_req;

    logic [5:0]  mq;
    int          n_chk  = 0;
    int          n_fail = 0;
    bit          done   = 0;

    always #4 clk = ~clk;

    ppl_slice i_ppl_slice (
        .clk(clk), .rst(rst), .pt_in(pt_in), .pt_raw(pt_raw), .tmr_pin(tmr_pin),
        .cfg_reg(cfg_reg), .cfg_inv(cfg_inv), .tmr_sel(tmr_sel),
        .tmr_strobe(tmr_strobe), .irq_req(irq_req)
    );

    function automatic logic exp_cell(int i);
        logic live;
        live = |pt_in[2*i +: 2];
        return (cfg_reg[i] ? mq[i] : live) ^ cfg_inv[i];
    endfunction

    function automatic logic exp_strobe(int j);
        return tmr_sel[j] ? exp_cell(j) : tmr_pin[j];
    endfunction

    function automatic logic exp_irq(int k);
        return (k < 2) ? pt_raw[k] : exp_cell(k + 2);
    endfunction

    task automatic check_bit(string tag, string what, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %b expected %b at %0t", tag, what, got, exp, $time);
        end
    endtask

    // Compare all outputs; tag "" picks the requirement from the configuration.
    task automatic check_all(string tag);
        string t;
        #1;
        for (int j = 0; j < 4; j++) begin
            if (tag != "") t = tag;
            else if (!tmr_sel[j]) t = "R4";
            else t = cfg_reg[j] ? "R2" : "R1";
            check_bit(t, $sformatf("tmr_strobe[%0d]", j), tmr_strobe[j], exp_strobe(j));
        end
        for (int k = 0; k < 4; k++) begin
            if (tag != "") t = tag;
            else t = (k < 2) ? "R5" : "R6";
            check_bit(t, $sformatf("irq_req[%0d]", k), irq_req[k], exp_irq(k));
        end
    endtask

    task automatic tick();
        @(posedge clk);
        for (int i = 0; i < 6; i++) mq[i] = rst ? 1'b0 : |pt_in[2*i +: 2];
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; pt_in = '1; pt_raw = '0; tmr_pin = '0;
        cfg_reg = '1; cfg_inv = 6'b101010; tmr_sel = '1;
        mq = '0;
        tick();
        // R3: registered cells after a reset edge show only the polarity bit
        check_all("R3");
        tick();
        rst = 1'b0;
        pt_in = '0;
        check_all("R3");
        tick();

        // R1: combinational mode, several patterns, no clock between change and check
        cfg_reg = '0; cfg_inv = '0;
        pt_in = 12'b01_10_00_11_01_00; check_all("R1");
        pt_in = 12'b00_00_11_00_10_01; check_all("R1");
        cfg_inv = 6'b110011;           check_all("R1");
        tick();

        // R7: register kept sampling while combinational; switch to registered
        pt_in = 12'b11_00_01_00_10_00;
        tick();
        pt_in = 12'b00_11_00_10_00_01;
        cfg_reg = '1;
        check_all("R7");
        tick();

        // R8: flip polarity on registered cells without a clock edge
        pt_in = '0;
        tick();
        cfg_inv = ~cfg_inv;
        check_all("R8");
        cfg_inv = ~cfg_inv;
        check_all("R8");
        tick();

        // R4: pins selected, cells busy
        tmr_sel = '0; tmr_pin = 4'b1001; pt_in = '1;
        check_all("R4");
        tmr_pin = 4'b0110;
        check_all("R4");
        tick();

        // R5: raw terms with all cells inverted
        cfg_inv = '1; pt_raw = 2'b01; check_all("R5");
        pt_raw = 2'b10;               check_all("R5");
        tick();

        // R6: interrupt cells, one registered, one combinational
        cfg_reg = 6'b010000; pt_in = 12'b10_01_00_00_00_00;
        check_all("R6");
        tick();
        check_all("R6");
        tick();

        // random mix
        for (int n = 0; n < 400; n++) begin
            pt_in   = 12'($urandom);
            pt_raw  = 2'($urandom);
            tmr_pin = 4'($urandom);
            tmr_sel = 4'($urandom);
            if ($urandom % 4 == 0) cfg_reg = 6'($urandom);
            if ($urandom % 4 == 0) cfg_inv = 6'($urandom);
            if ($urandom % 40 == 0) rst = 1'b1;
            check_all(rst ? "R3" : "");
            tick();
            rst = 1'b0;
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule